// File: doc/BRIEF.md
# SDRAM Command Queue Scheduler

This block keeps up to eight memory commands waiting in one shared queue and decides, every cycle, which of them the SDRAM sequencer should run next. Each command records its direction, the interface it came from, its transaction tag, its byte address, a three-bit priority, whether it targets a control register, and its arrival order. The scheduler finds the best read and the best write separately, then offers one of them on an issue handshake. It accounts for address hazards, open banks, free space in the downstream FIFOs and the bus timing state.

Issued entries stay in the queue until a completion strobe retires them by index. Until then they still hold back younger commands that conflict with them. An age timer keeps a stream of high-priority traffic from starving the oldest waiting command.

Top module: `cmdSched`

## Requirements
- R1: A command is accepted on a cycle with `inValid` and `inReady` both high. `inReady` is low while eight entries are held, and a command offered then is dropped. A new command takes the lowest free entry index.
- R2: A command is not offered while any older entry that has not been retired has the same 2048-byte block (address bits 31 down to 11 equal), whatever its priority or source.
- R3: A command is not offered while an older entry that has not been retired has the same source and the same tag. Commands with a different source or a different tag are not held back by it.
- R4: An entry counts only if its bank is open. The bank is address bits 13 down to 11, looked up in `bankOpen`. A register-access entry always counts as open.
- R5: Among the qualifying commands of one direction, the one with the lowest priority value wins (0 is the most urgent). Ties go to the oldest.
- R6: When timing is met and neither FIFO is full, the read candidate is offered in preference to the write candidate.
- R7: When `rdFifoFull` is high, only the write candidate may be offered. Nothing is offered while `retFifoFull` is high or `timingOk` is low.
- R8: When the oldest entry has waited unissued for `ageLimit` cycles after becoming oldest, it is offered alone, bypassing the bank filter and the priority rules, as soon as timing and FIFO space allow.
- R9: Reset empties the queue at once. After reset nothing is offered and `inReady` is high.
- R10: An offered entry is issued on a cycle with `issueReady` high and is never offered again. `doneValid` with the index of an issued entry removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears the queue |
| inValid | input | 1 | New command present |
| inReady | output | 1 | Queue has a free entry |
| inWrite | input | 1 | 1 = write, 0 = read |
| inSrc | input | 2 | Source interface number |
| inTag | input | 4 | Transaction tag |
| inAddr | input | 32 | Byte address |
| inPrio | input | 3 | Priority, 0 most urgent |
| inReg | input | 1 | Command targets a control register |
| bankOpen | input | 8 | One bit per bank, 1 = row open |
| rdFifoFull | input | 1 | Read data FIFO has no space |
| retFifoFull | input | 1 | Return command FIFO has no space |
| timingOk | input | 1 | Command spacing and turnaround satisfied |
| ageLimit | input | 8 | Starvation timer reload value |
| issueValid | output | 1 | A command is offered |
| issueReady | input | 1 | Sequencer takes the offered command |
| issueIdx | output | 3 | Entry index of the offered command |
| issueWrite | output | 1 | Direction of the offered command |
| issueAddr | output | 32 | Address of the offered command |
| doneValid | input | 1 | Completion strobe |
| doneIdx | input | 3 | Entry index being retired |

## Verification
The bench checks that a read to a block still held by an older issued write stays hidden until that write retires. A design that looks only at entries waiting to issue would let the read pass the write. It also checks that same-tag commands from one source run in order while a command from another source overtakes them, and that equal priorities resolve to the oldest entry rather than the lowest index. The FIFO-full and timing combinations are walked through to catch a read issued with no room for its data. A starved entry on a closed bank must win once its timer runs out; a design that kept the bank filter for the boosted entry would stall the queue for good.

// File: rtl/cmdSchedPkg.sv
package cmdSchedPkg;
  localparam int DEPTH   = 8;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int CNT_W   = IDX_W + 1;
  localparam int ADDR_W  = 32;
  localparam int SRC_W   = 2;
  localparam int TAG_W   = 4;
  localparam int PRIO_W  = 3;
  localparam int BLK_LSB = 11;

  typedef struct packed {
    logic              isWr;
    logic [SRC_W-1:0]  src;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [PRIO_W-1:0] prio;
    logic              isReg;
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             alloc;
    logic [IDX_W-1:0] allocIdx;
    logic             issue;
    logic [IDX_W-1:0] issueIdx;
    logic             retire;
    logic [IDX_W-1:0] retireIdx;
  } stb_t;
endpackage

// File: rtl/cmdSchedData.sv
module cmdSchedData
  import cmdSchedPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stb_t             stb,
  input  cmd_t             inCmd,
  output cmd_t             ent [DEPTH],
  output logic [DEPTH-1:0] vld,
  output logic [DEPTH-1:0] iss,
  output logic [IDX_W-1:0] ord [DEPTH],
  output logic [CNT_W-1:0] cnt
);
  logic [IDX_W-1:0] ordNxt [DEPTH];
  logic [CNT_W-1:0] cntNxt;

  // age queue: remove retired index, shift younger ones up, append new one
  always_comb begin
    logic [CNT_W-1:0] rmPos;
    logic [CNT_W-1:0] base;
    rmPos = CNT_W'(DEPTH);
    for (int k = DEPTH - 1; k >= 0; k--)
      if (CNT_W'(k) < cnt && ord[k] == stb.retireIdx) rmPos = CNT_W'(k);
    for (int k = 0; k < DEPTH; k++) begin
      if (stb.retire && CNT_W'(k) >= rmPos)
        ordNxt[k] = (k + 1 < DEPTH) ? ord[(k + 1) % DEPTH] : '0;
      else
        ordNxt[k] = ord[k];
    end
    base = cnt - CNT_W'(stb.retire);
    for (int k = 0; k < DEPTH; k++)
      if (stb.alloc && CNT_W'(k) == base) ordNxt[k] = stb.allocIdx;
    cntNxt = base + CNT_W'(stb.alloc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      iss <= '0;
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) ord[k] <= '0;
    end else begin
      if (stb.alloc) begin
        vld[stb.allocIdx] <= 1'b1;
        iss[stb.allocIdx] <= 1'b0;
      end
      if (stb.issue)  iss[stb.issueIdx]  <= 1'b1;
      if (stb.retire) vld[stb.retireIdx] <= 1'b0;
      ord <= ordNxt;
      cnt <= cntNxt;
    end
  end

  always_ff @(posedge clk)
    if (stb.alloc) ent[stb.allocIdx] <= inCmd;
endmodule

// File: rtl/cmdSchedCtrl.sv
module cmdSchedCtrl
  import cmdSchedPkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int BANK_LSB = 11,
  parameter int AGE_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cmd_t                   ent [DEPTH],
  input  logic [DEPTH-1:0]       vld,
  input  logic [DEPTH-1:0]       iss,
  input  logic [IDX_W-1:0]       ord [DEPTH],
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   inValid,
  input  logic [(1<<BANK_W)-1:0] bankOpen,
  input  logic                   rdFifoFull,
  input  logic                   retFifoFull,
  input  logic                   timingOk,
  input  logic [AGE_W-1:0]       ageLimit,
  input  logic                   issueReady,
  input  logic                   doneValid,
  input  logic [IDX_W-1:0]       doneIdx,
  output stb_t                   stb,
  output logic                   inReady,
  output logic                   issueValid,
  output logic [IDX_W-1:0]       issueIdx,
  output logic                   issueWrite,
  output logic [ADDR_W-1:0]      issueAddr,
  output logic                   boostAct,
  output logic [IDX_W-1:0]       headId
);
  logic [IDX_W-1:0] pos [DEPTH];
  logic [DEPTH-1:0] blocked, qual;
  logic             rdHit, wrHit;
  logic [IDX_W-1:0] rdIdx, wrIdx, freeIdx;
  logic [AGE_W-1:0] ageCnt;
  logic [IDX_W-1:0] prevHead;
  logic             prevPend, headPend, canGo;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) pos[i] = '0;
    for (int k = 0; k < DEPTH; k++)
      if (CNT_W'(k) < cnt) pos[ord[k]] = IDX_W'(k);
  end

  // hazard and stream-order blocking against older live entries
  always_comb begin
    blocked = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (i != j && vld[i] && vld[j] && pos[j] < pos[i] &&
            ((ent[i].addr[ADDR_W-1:BLK_LSB] == ent[j].addr[ADDR_W-1:BLK_LSB]) ||
             (ent[i].src == ent[j].src && ent[i].tag == ent[j].tag)))
          blocked[i] = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      qual[i] = vld[i] && !iss[i] && !blocked[i] &&
                (ent[i].isReg || bankOpen[ent[i].addr[BANK_LSB +: BANK_W]]);
  end

  // best read and best write, scanned oldest first so ties keep the oldest
  always_comb begin
    logic [IDX_W-1:0]  id;
    logic [PRIO_W-1:0] rdPri, wrPri;
    rdHit = 1'b0; rdIdx = '0; rdPri = '1;
    wrHit = 1'b0; wrIdx = '0; wrPri = '1;
    id = '0;
    for (int k = 0; k < DEPTH; k++) begin
      id = ord[k];
      if (CNT_W'(k) < cnt && qual[id]) begin
        if (ent[id].isWr) begin
          if (!wrHit || ent[id].prio < wrPri) begin
            wrHit = 1'b1; wrIdx = id; wrPri = ent[id].prio;
          end
        end else if (!rdHit || ent[id].prio < rdPri) begin
          rdHit = 1'b1; rdIdx = id; rdPri = ent[id].prio;
        end
      end
    end
  end

  always_comb begin
    freeIdx = '0;
    for (int k = DEPTH - 1; k >= 0; k--)
      if (!vld[k]) freeIdx = IDX_W'(k);
  end

  assign headId   = ord[0];
  assign headPend = (cnt != '0) && !iss[headId];
  assign boostAct = headPend && prevPend && (headId == prevHead) && (ageCnt == '0);
  assign canGo    = timingOk && !retFifoFull;

  always_comb begin
    issueValid = 1'b0;
    issueIdx   = '0;
    if (boostAct) begin
      issueIdx   = headId;
      issueValid = canGo && (ent[headId].isWr || !rdFifoFull);
    end else if (canGo) begin
      if (rdHit && !rdFifoFull) begin
        issueValid = 1'b1; issueIdx = rdIdx;
      end else if (wrHit) begin
        issueValid = 1'b1; issueIdx = wrIdx;
      end
    end
  end

  assign issueWrite = ent[issueIdx].isWr;
  assign issueAddr  = ent[issueIdx].addr;
  assign inReady    = (cnt != CNT_W'(DEPTH));

  always_comb begin
    stb.alloc     = inValid && inReady;
    stb.allocIdx  = freeIdx;
    stb.issue     = issueValid && issueReady;
    stb.issueIdx  = issueIdx;
    stb.retire    = doneValid && vld[doneIdx] && iss[doneIdx];
    stb.retireIdx = doneIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt   <= '0;
      prevHead <= '0;
      prevPend <= 1'b0;
    end else begin
      if (!headPend || !prevPend || headId != prevHead ||
          (stb.issue && stb.issueIdx == headId))
        ageCnt <= ageLimit;
      else if (ageCnt != '0)
        ageCnt <= ageCnt - 1'b1;
      prevHead <= headId;
      prevPend <= headPend;
    end
  end
endmodule

// File: rtl/cmdSched.sv
module cmdSched
  import cmdSchedPkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int BANK_LSB = 11,
  parameter int AGE_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic                   inWrite,
  input  logic [SRC_W-1:0]       inSrc,
  input  logic [TAG_W-1:0]       inTag,
  input  logic [ADDR_W-1:0]      inAddr,
  input  logic [PRIO_W-1:0]      inPrio,
  input  logic                   inReg,
  input  logic [(1<<BANK_W)-1:0] bankOpen,
  input  logic                   rdFifoFull,
  input  logic                   retFifoFull,
  input  logic                   timingOk,
  input  logic [AGE_W-1:0]       ageLimit,
  output logic                   issueValid,
  input  logic                   issueReady,
  output logic [IDX_W-1:0]       issueIdx,
  output logic                   issueWrite,
  output logic [ADDR_W-1:0]      issueAddr,
  input  logic                   doneValid,
  input  logic [IDX_W-1:0]       doneIdx
);
  cmd_t             inCmd;
  cmd_t             ent [DEPTH];
  logic [DEPTH-1:0] vld, iss;
  logic [IDX_W-1:0] ord [DEPTH];
  logic [CNT_W-1:0] cnt;
  stb_t             stb;
  logic             boostAct;
  logic [IDX_W-1:0] headId;

  assign inCmd = '{isWr: inWrite, src: inSrc, tag: inTag, addr: inAddr,
                   prio: inPrio, isReg: inReg};

  cmdSchedData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inCmd(inCmd),
    .ent(ent), .vld(vld), .iss(iss), .ord(ord), .cnt(cnt)
  );

  cmdSchedCtrl #(.BANK_W(BANK_W), .BANK_LSB(BANK_LSB), .AGE_W(AGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ent(ent), .vld(vld), .iss(iss), .ord(ord), .cnt(cnt),
    .inValid(inValid), .bankOpen(bankOpen), .rdFifoFull(rdFifoFull),
    .retFifoFull(retFifoFull), .timingOk(timingOk), .ageLimit(ageLimit),
    .issueReady(issueReady), .doneValid(doneValid), .doneIdx(doneIdx),
    .stb(stb), .inReady(inReady), .issueValid(issueValid), .issueIdx(issueIdx),
    .issueWrite(issueWrite), .issueAddr(issueAddr), .boostAct(boostAct),
    .headId(headId)
  );
endmodule

// File: rtl/cmdSchedChk.sv
module cmdSchedChk
  import cmdSchedPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             timingOk,
  input logic             retFifoFull,
  input logic             rdFifoFull,
  input logic             issueValid,
  input logic             issueWrite,
  input logic [IDX_W-1:0] issueIdx,
  input logic             boostAct,
  input logic [IDX_W-1:0] headId
);
  a_r7_hold_on_timing: assert property (@(posedge clk) disable iff (!rstN)
    !timingOk |-> !issueValid);

  a_r7_hold_on_return_full: assert property (@(posedge clk) disable iff (!rstN)
    retFifoFull |-> !issueValid);

  a_r7_read_needs_room: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueWrite) |-> !rdFifoFull);

  a_r8_boost_picks_head: assert property (@(posedge clk) disable iff (!rstN)
    (boostAct && issueValid) |-> (issueIdx == headId));
endmodule

bind cmdSched cmdSchedChk uChk (
  .clk(clk), .rstN(rstN), .timingOk(timingOk), .retFifoFull(retFifoFull),
  .rdFifoFull(rdFifoFull), .issueValid(issueValid), .issueWrite(issueWrite),
  .issueIdx(issueIdx), .boostAct(boostAct), .headId(headId)
);

// File: tb/sim_cmdSched.sv
`timescale 1ns/1ps
module sim_cmdSched;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inWrite = 1'b0, inReg = 1'b0;
  logic        inReady;
  logic [1:0]  inSrc = '0;
  logic [3:0]  inTag = '0;
  logic [31:0] inAddr = '0;
  logic [2:0]  inPrio = '0;
  logic [7:0]  bankOpen = 8'hFF;
  logic        rdFifoFull = 1'b0, retFifoFull = 1'b0, timingOk = 1'b1;
  logic [7:0]  ageLimit = 8'd255;
  logic        issueValid, issueWrite;
  logic        issueReady = 1'b0;
  logic [2:0]  issueIdx;
  logic [31:0] issueAddr;
  logic        doneValid = 1'b0;
  logic [2:0]  doneIdx = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmdSched u0 (.*);

  // {isWr, isReg, bankOn, rdFull, retFull, tOk, expValid}
  localparam logic [6:0] VEC [8] = '{
    7'b0010011,  // R6 plain read issues
    7'b0011010,  // R7 read held by full read FIFO
    7'b1011011,  // R7 write passes full read FIFO
    7'b1010110,  // R7 return FIFO full
    7'b0010000,  // R7 timing not met
    7'b0000010,  // R4 closed bank
    7'b0100011,  // R4 register access counts as open
    7'b1000010   // R4 closed bank write
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic push(input logic w, input logic [1:0] s, input logic [3:0] t,
                      input logic [31:0] blk, input logic [2:0] p, input logic r);
    @(negedge clk);
    inValid = 1'b1; inWrite = w; inSrc = s; inTag = t;
    inAddr = (blk << 11) | 32'h24; inPrio = p; inReg = r;
    @(negedge clk);
    inValid = 1'b0;
    #1;
  endtask

  task automatic take();
    @(negedge clk); issueReady = 1'b1;
    @(negedge clk); issueReady = 1'b0;
    #1;
  endtask

  task automatic retire(input logic [2:0] idx);
    @(negedge clk); doneValid = 1'b1; doneIdx = idx;
    @(negedge clk); doneValid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    #1;
    chk("R9 reset issueValid", issueValid, 0);
    chk("R9 reset inReady", inReady, 1);

    // vector table
    foreach (VEC[v]) begin
      doReset();
      rdFifoFull = 1'b0; retFifoFull = 1'b0; timingOk = 1'b1; bankOpen = 8'hFF;
      push(VEC[v][6], 2'd0, 4'd1, 32'd1, 3'd4, VEC[v][5]);
      @(negedge clk);
      bankOpen = VEC[v][4] ? 8'hFF : 8'hFD;
      rdFifoFull = VEC[v][3]; retFifoFull = VEC[v][2]; timingOk = VEC[v][1];
      #1;
      chk($sformatf("R4/R6/R7 vector %0d valid", v), issueValid, VEC[v][0]);
      if (VEC[v][0]) chk($sformatf("R6/R7 vector %0d idx", v), issueIdx, 0);
    end
    rdFifoFull = 1'b0; retFifoFull = 1'b0; timingOk = 1'b1; bankOpen = 8'hFF;

    // R5 priority then oldest
    doReset();
    push(0, 2'd0, 4'd1, 32'd1, 3'd5, 0);
    push(0, 2'd0, 4'd2, 32'd2, 3'd2, 0);
    push(0, 2'd0, 4'd3, 32'd3, 3'd2, 0);
    chk("R5 best priority oldest tie", issueIdx, 1);
    take();
    chk("R5 next tie entry", issueIdx, 2);
    chk("R10 issued entry not reoffered valid", issueValid, 1);

    // R2 block hazard held by issued write
    doReset();
    push(1, 2'd0, 4'd1, 32'd4, 3'd7, 0);
    push(0, 2'd0, 4'd2, 32'd4, 3'd0, 0);
    chk("R2 older write first", issueIdx, 0);
    chk("R2 older write dir", issueWrite, 1);
    take();
    chk("R2 read held behind issued write", issueValid, 0);
    retire(3'd0);
    chk("R10 retire frees hazard valid", issueValid, 1);
    chk("R10 retire frees hazard idx", issueIdx, 1);

    // R3 stream ordering
    doReset();
    push(0, 2'd0, 4'd5, 32'd1, 3'd7, 0);
    push(0, 2'd0, 4'd5, 32'd2, 3'd0, 0);
    chk("R3 same stream stays in order", issueIdx, 0);
    push(0, 2'd1, 4'd5, 32'd3, 3'd1, 0);
    chk("R3 other source overtakes", issueIdx, 2);
    take(); retire(3'd2);
    chk("R3 oldest of stream next", issueIdx, 0);
    take();
    chk("R3 younger waits for completion", issueValid, 0);
    retire(3'd0);
    chk("R3 younger after completion", issueIdx, 1);

    // R6 / R7 read versus write
    doReset();
    push(1, 2'd0, 4'd1, 32'd1, 3'd0, 0);
    push(0, 2'd0, 4'd2, 32'd2, 3'd7, 0);
    chk("R6 read preferred idx", issueIdx, 1);
    chk("R6 read preferred dir", issueWrite, 0);
    @(negedge clk); rdFifoFull = 1'b1; #1;
    chk("R7 write when read FIFO full", issueIdx, 0);
    chk("R7 write dir", issueWrite, 1);
    rdFifoFull = 1'b0;

    // R1 full queue
    doReset();
    for (int k = 0; k < 8; k++) push(0, 2'd0, 4'(k), 32'(k + 1), 3'd3, 0);
    chk("R1 full inReady", inReady, 0);
    push(0, 2'd1, 4'd9, 32'd20, 3'd0, 0);
    chk("R1 refused command not offered", issueIdx, 0);
    take(); retire(3'd0);
    chk("R1 slot freed", inReady, 1);
    push(0, 2'd1, 4'd9, 32'd21, 3'd0, 0);
    chk("R1 lowest free index reused", issueIdx, 0);
    chk("R1 reused entry address", issueAddr, (32'd21 << 11) | 32'h24);

    // R9 reset clears a loaded queue
    doReset();
    #1;
    chk("R9 cleared issueValid", issueValid, 0);
    chk("R9 cleared inReady", inReady, 1);

    // R8 age boost
    doReset();
    ageLimit = 8'd4;
    bankOpen = 8'hFD;
    push(0, 2'd0, 4'd1, 32'd1, 3'd7, 0);
    push(0, 2'd0, 4'd2, 32'd2, 3'd0, 0);
    chk("R8 before expiry open bank wins", issueIdx, 1);
    repeat (10) @(negedge clk);
    #1;
    chk("R8 boosted oldest valid", issueValid, 1);
    chk("R8 boosted oldest idx", issueIdx, 0);
    take();
    chk("R8 after boost normal pick", issueIdx, 1);
    ageLimit = 8'd255;
    bankOpen = 8'hFF;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule